// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block turns single-beat memory requests from a small processor core into external bus cycles on a bus that shares its low address byte with the data byte and carries the high address byte on separate lines. The core presents an opcode fetch, a data read or a data write with a 16-bit address and, for a write, an 8-bit data byte. The block runs one bus cycle of four bus states and drives the address-latch strobe, the active-low read and write strobes, the high address lines, and the shared low lines with their output enable.

Every bus state lasts three clocks of the block's clock, which is the oscillator. A cycle therefore lasts twelve clocks, numbered 0 to 11 from the first clock after the request is taken. Read and fetch data are sampled from the shared lines near the end of the third state. They are returned to the core in the fourth state together with a one-clock completion pulse. Requests are taken only while the bus is idle or in the last clock of a cycle, so two cycles can follow each other with no gap.

Top module: `xbus_cycle_seq`

## Requirements
- R1: While reset is held and after it is released with no request, the block is idle: `req_ready` is 1, `bus_ale` is 0, `bus_rd_n` and `bus_wr_n` are 1, `bus_ad_oe` is 0 and `rsp_done` is 0.
- R2: A taken request starts a cycle of exactly 12 clocks, made of four states of three clocks each. `req_ready` is 0 in clocks 0 to 10 and is 1 in clock 11.
- R3: During all 12 clocks of a cycle, `bus_ahi` equals bits 15:8 of the request address.
- R4: In clocks 0 to 2, `bus_ad_oe` is 1 and `bus_ad_out` equals bits 7:0 of the address. `bus_ale` is 1 in clocks 0 and 1 and is 0 from clock 2 on, so it falls while the address is still on the shared lines.
- R5: For a fetch or a read, `bus_ad_oe` is 0 in clocks 3 to 11 and `bus_rd_n` is 0 in clocks 3 to 8. The byte on `bus_ad_in` is sampled during clock 8.
- R6: For a fetch or a read, `rsp_done` is 1 for clock 9 only and `rsp_data` then holds the sampled byte. A write produces no `rsp_done`.
- R7: For a write, `bus_wr_n` is 0 in clocks 1 to 5 and rises at the start of clock 6. `bus_ad_out` carries the write data in clocks 3 to 8. `bus_ad_oe` is 1 in clocks 0 to 8 and 0 in clocks 9 to 11.
- R8: `bus_rd_n` and `bus_wr_n` are 1 whenever no access is in progress, and they are never 0 in the same clock.
- R9: A request is taken only when `req_valid` is 1 and `req_ready` is 1. A request held while the bus is busy has no effect on any bus output. A request taken in clock 11 makes the next clock clock 0 of the new cycle.
- R10: `req_kind` encoding: 0 is fetch, 1 is read, 2 is write, and 3 is handled as a write. A fetch and a read give identical bus waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one bus state is three of its periods |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 2 | Cycle type (see R10) |
| req_addr | input | 16 | Byte address of the access |
| req_wdata | input | 8 | Data byte for a write |
| req_ready | output | 1 | A request presented now is taken |
| rsp_done | output | 1 | One-clock pulse: read or fetch data valid |
| rsp_data | output | 8 | Last byte read from the bus |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ahi | output | 8 | High address byte |
| bus_ad_out | output | 8 | Shared low lines, outgoing value |
| bus_ad_oe | output | 1 | Output enable of the shared low lines |
| bus_ad_in | input | 8 | Shared low lines, incoming value |

## Verification
Two things can happen in the same clock: the end of one cycle, where the fourth state carries the completion pulse of a read, and the taking of the next request. The bench keeps `req_valid` high with the next request all through a busy cycle. This provokes both a back-to-back start in clock 11 and requests that must be ignored in clocks 0 to 10; gaps are also inserted now and then so that starts from idle occur too. A behavioural model, driven only by the 12-clock timeline of the requirements, predicts every strobe, enable, address byte, ready and done value on every clock. A bus-level memory that latches the address on the falling strobe serves reads and takes writes on the rising write strobe, so a strobe edge in the wrong clock shows up as wrong data as well as a miscompare.

// File: rtl/xbus_pkg.sv
// Package xbus_pkg
// Shared cycle-type encoding for the multiplexed bus sequencer.
// Assumes a 2-bit request kind; bit 1 set means a write cycle.
package xbus_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_WRALT = 2'd3
    } xbus_kind_e;

    // Decide whether a kind code drives data onto the bus
    function automatic logic kind_is_write(input logic [1:0] kind);
        return kind[1];
    endfunction

endpackage

// File: rtl/xbus_timebase.sv
// Module xbus_timebase
// Phase counter (oscillator clocks inside a bus state) and state counter
// (T1..T4 inside a bus cycle). A start pulse restarts at T1 phase 0, even
// in the last clock of a running cycle. Assumes PHASES >= 2, STATES >= 2.
module xbus_timebase #(
    parameter int PHASES = 3,
    parameter int STATES = 4,
    localparam int PH_W = $clog2(PHASES),
    localparam int TS_W = $clog2(STATES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            active,
    output logic [PH_W-1:0] phase,
    output logic [TS_W-1:0] tstate,
    output logic            at_end
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
    localparam logic [TS_W-1:0] TS_LAST = TS_W'(STATES - 1);

    // Advance phase every clock and state on each phase wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= '0;
            tstate <= '0;
        end else if (start) begin
            active <= 1'b1;
            phase  <= '0;
            tstate <= '0;
        end else if (active) begin
            if (phase == PH_LAST) begin
                phase <= '0;
                if (tstate == TS_LAST) begin
                    active <= 1'b0;
                    tstate <= '0;
                end else begin
                    tstate <= tstate + 1'b1;
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Flag the final oscillator clock of a cycle
    always_comb at_end = active && (phase == PH_LAST) && (tstate == TS_LAST);

    // Phase never leaves its modulo range
    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_LAST)
        else $error("phase out of range");

    // State only moves when the phase wraps
    assert_state_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && phase != PH_LAST && !start) |=> $stable(tstate))
        else $error("state moved mid-state");

endmodule

// File: rtl/xbus_strobes.sv
// Module xbus_strobes
// Decodes the bus strobes and the low-bus driver controls from the
// position (state, phase) inside the cycle and the cycle type.
// Purely combinational; assumes its inputs come straight from registers.
module xbus_strobes #(
    parameter int PHASES = 3,
    parameter int STATES = 4,
    localparam int PH_W = $clog2(PHASES),
    localparam int TS_W = $clog2(STATES)
) (
    input  logic            active,
    input  logic [PH_W-1:0] phase,
    input  logic [TS_W-1:0] tstate,
    input  logic            is_write,
    output logic            ale,
    output logic            rd_n,
    output logic            wr_n,
    output logic            ad_oe,
    output logic            ad_data_sel,
    output logic            capture
);

    localparam logic [TS_W-1:0] S_ADDR  = TS_W'(0);
    localparam logic [TS_W-1:0] S_MID   = TS_W'(1);
    localparam logic [TS_W-1:0] S_XFER  = TS_W'(2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(PHASES / 2);

    logic in_addr;
    logic in_mid;
    logic in_xfer;

    // Locate the current bus state
    always_comb begin
        in_addr = active && (tstate == S_ADDR);
        in_mid  = active && (tstate == S_MID);
        in_xfer = active && (tstate == S_XFER);
    end

    // Strobe and driver decode
    always_comb begin
        ale         = in_addr && (phase != PH_LAST);
        rd_n        = !(!is_write && (in_mid || in_xfer));
        wr_n        = !(is_write && ((in_addr && phase >= PH_HALF) || in_mid));
        ad_oe       = in_addr || (is_write && (in_mid || in_xfer));
        ad_data_sel = !in_addr;
        capture     = !is_write && in_xfer && (phase == PH_LAST);
    end

endmodule

// File: rtl/xbus_cycle_seq.sv
// Module xbus_cycle_seq (top)
// Runs one four-state external bus cycle per taken request on a bus with a
// shared low address/data byte and a separate high address byte. A state
// is PHASES oscillator clocks. Requests are taken while idle or in the last
// clock of a cycle. Read data is sampled at the end of the third state and
// returned with a one-clock done pulse in the fourth.
// Assumes the external address latch is transparent while bus_ale is high.
module xbus_cycle_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PHASES = 3,
    parameter int STATES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rsp_done,
    output logic [DATA_W-1:0]    rsp_data,
    output logic                 bus_ale,
    output logic                 bus_rd_n,
    output logic                 bus_wr_n,
    output logic [ADDR_W-DATA_W-1:0] bus_ahi,
    output logic [DATA_W-1:0]    bus_ad_out,
    output logic                 bus_ad_oe,
    input  logic [DATA_W-1:0]    bus_ad_in
);

    localparam int PH_W = $clog2(PHASES);
    localparam int TS_W = $clog2(STATES);
    localparam int HI_W = ADDR_W - DATA_W;

    logic            start;
    logic            tb_active;
    logic [PH_W-1:0] tb_phase;
    logic [TS_W-1:0] tb_state;
    logic            tb_end;
    logic            is_write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic            ad_data_sel;
    logic            capture;

    // Handshake: take a request when idle or finishing
    always_comb begin
        req_ready = !tb_active || tb_end;
        start     = req_valid && req_ready;
    end

    xbus_timebase #(
        .PHASES (PHASES),
        .STATES (STATES)
    ) i_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (tb_active),
        .phase  (tb_phase),
        .tstate (tb_state),
        .at_end (tb_end)
    );

    // Hold the request for the length of the cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_write_q <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
        end else if (start) begin
            is_write_q <= kind_is_write(req_kind);
            addr_q     <= req_addr;
            wdata_q    <= req_wdata;
        end
    end

    xbus_strobes #(
        .PHASES (PHASES),
        .STATES (STATES)
    ) i_strobes (
        .active      (tb_active),
        .phase       (tb_phase),
        .tstate      (tb_state),
        .is_write    (is_write_q),
        .ale         (bus_ale),
        .rd_n        (bus_rd_n),
        .wr_n        (bus_wr_n),
        .ad_oe       (bus_ad_oe),
        .ad_data_sel (ad_data_sel),
        .capture     (capture)
    );

    // Drive the address bytes and select address or write data on AD
    always_comb begin
        bus_ahi    = addr_q[ADDR_W-1 -: HI_W];
        bus_ad_out = ad_data_sel ? wdata_q : addr_q[DATA_W-1:0];
    end

    // Sample read data and raise the one-clock completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_done <= capture;
            if (capture) begin
                rsp_data <= bus_ad_in;
            end
        end
    end

    // Address still on AD when the latch strobe falls
    assert_ale_before_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ale) |-> (bus_ad_oe && $stable(bus_ad_out)))
        else $error("ALE fell while AD changed");

    // No driver contention while memory drives AD
    assert_rd_bus_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe)
        else $error("AD driven during read strobe");

    // Done follows a clock with the read strobe active
    assert_done_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(!bus_rd_n))
        else $error("done without read");

    // Done lasts one clock
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done)
        else $error("done longer than one clock");

    // Write data still driven when write strobe rises
    assert_wr_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |-> (bus_ad_oe && $stable(bus_ad_out)))
        else $error("write data not held");

    // Read and write strobes exclusive
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_n || bus_wr_n)
        else $error("RD and WR both low");

    // High address constant inside a cycle
    assert_ahi_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_active && $past(tb_active) && !$past(start)) |-> $stable(bus_ahi))
        else $error("high address moved in cycle");

endmodule

// File: tb/test_xbus_cycle_seq.sv
`timescale 1ns/1ps
module test_xbus_cycle_seq;

    localparam int NOPS = 40;
    localparam int WATCH_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic        rsp_done;
    logic [7:0]  rsp_data;
    logic        bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe;
    logic [7:0]  bus_ahi, bus_ad_out, bus_ad_in;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xbus_cycle_seq i_xbus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .bus_ale(bus_ale),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ahi(bus_ahi),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
    );

    // Bus-level memory with its own address latch
    logic [7:0]  mem [256];
    logic [7:0]  exp_mem [256];
    logic [15:0] ext_latch = 16'h0;

    function automatic logic [7:0] idx(input logic [15:0] a);
        return a[7:0] ^ a[15:8];
    endfunction

    always @(negedge bus_ale) ext_latch <= {bus_ahi, bus_ad_out};
    always @(posedge bus_wr_n) if (rst_n === 1'b1) mem[idx(ext_latch)] = bus_ad_out;
    assign bus_ad_in = (bus_rd_n === 1'b0) ? mem[idx(ext_latch)] : 8'hEE;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model state: position in a 12-clock timeline
    bit          m_active = 0;
    int          m_pos = 0;
    bit          m_write = 0;
    logic [15:0] m_addr = 0;
    logic [7:0]  m_wdata = 0;
    logic [7:0]  m_rdata = 0;

    task automatic compare();
        bit e_ale, e_rd_n, e_wr_n, e_oe, e_done, e_rdy;
        logic [7:0] e_ad;
        e_ale  = m_active && m_pos < 2;
        e_rd_n = !(m_active && !m_write && m_pos >= 3 && m_pos <= 8);
        e_wr_n = !(m_active && m_write && m_pos >= 1 && m_pos <= 5);
        e_oe   = m_active && (m_pos < 3 || (m_write && m_pos < 9));
        e_ad   = (m_pos < 3) ? m_addr[7:0] : m_wdata;
        e_done = m_active && !m_write && m_pos == 9;
        e_rdy  = !m_active || m_pos == 11;
        chk(bus_ale === e_ale, "R4", "ale", 16'(bus_ale), 16'(e_ale));
        chk(bus_rd_n === e_rd_n, "R5", "rd_n", 16'(bus_rd_n), 16'(e_rd_n));
        chk(bus_wr_n === e_wr_n, "R7", "wr_n", 16'(bus_wr_n), 16'(e_wr_n));
        chk(bus_ad_oe === e_oe, m_write ? "R7" : "R5", "ad_oe", 16'(bus_ad_oe), 16'(e_oe));
        if (e_oe)
            chk(bus_ad_out === e_ad, (m_pos < 3) ? "R4" : "R7", "ad_out", 16'(bus_ad_out), 16'(e_ad));
        if (m_active)
            chk(bus_ahi === m_addr[15:8], "R3", "ahi", 16'(bus_ahi), 16'(m_addr[15:8]));
        chk(rsp_done === e_done, "R6", "done", 16'(rsp_done), 16'(e_done));
        if (e_done)
            chk(rsp_data === m_rdata, "R6", "rdata", 16'(rsp_data), 16'(m_rdata));
        chk(req_ready === e_rdy, "R2", "ready", 16'(req_ready), 16'(e_rdy));
        chk(bus_rd_n === 1'b1 || bus_wr_n === 1'b1, "R8", "strobe overlap",
            16'({bus_rd_n, bus_wr_n}), 16'h3);
        if (!m_active)
            chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, "R8", "idle strobes",
                16'({bus_rd_n, bus_wr_n}), 16'h3);
    endtask

    initial begin
        int opi;
        int gap_left;
        bit rdy_exp;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'((i * 37 + 11) & 255);
            exp_mem[i] = mem[i];
        end
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_kind = 2'd0;
        req_addr = 16'h0;
        req_wdata = 8'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready === 1'b1, "R1", "ready", 16'(req_ready), 16'h1);
        chk(bus_ale === 1'b0, "R1", "ale", 16'(bus_ale), 16'h0);
        chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, "R1", "strobes",
            16'({bus_rd_n, bus_wr_n}), 16'h3);
        chk(bus_ad_oe === 1'b0, "R1", "ad_oe", 16'(bus_ad_oe), 16'h0);
        chk(rsp_done === 1'b0, "R1", "done", 16'(rsp_done), 16'h0);
        rst_n = 1'b1;
        opi = 0;
        gap_left = 2;
        for (int cyc = 0; cyc < 5000; cyc++) begin
            @(negedge clk);
            compare();
            if (opi >= NOPS && !m_active) break;
            // Present next operation; held through busy clocks (R9)
            if (opi < NOPS && gap_left == 0) begin
                req_valid = 1'b1;
                // Triples write, read, fetch on one address; op 9 uses code 3 (R10)
                req_kind  = (opi == 9) ? 2'd3 : 2'(2 - (opi % 3));
                req_addr  = {8'((opi / 3) * 29 + 3), 8'((opi / 3) * 71 + 5)};
                req_wdata = 8'(opi * 53 + 17);
            end else begin
                req_valid = 1'b0;
                if (gap_left > 0) gap_left--;
            end
            rdy_exp = !m_active || m_pos == 11;
            if (req_valid && rdy_exp) begin
                m_active = 1;
                m_pos = 0;
                m_write = req_kind[1];
                m_addr = req_addr;
                m_wdata = req_wdata;
                if (m_write) exp_mem[idx(req_addr)] = req_wdata;
                else m_rdata = exp_mem[idx(req_addr)];
                opi++;
                if (opi % 5 == 4) gap_left = opi % 4 + 1;
            end else if (m_active) begin
                if (m_pos == 11) m_active = 0;
                else m_pos++;
            end
        end
        chk(opi == NOPS, "R9", "ops taken", 16'(opi), 16'(NOPS));
        // R7: memory contents after all bus writes
        for (int i = 0; i < 256; i++)
            chk(mem[i] === exp_mem[i], "R7", "memory", 16'(mem[i]), 16'(exp_mem[i]));
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * WATCH_CYC);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule